// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides which receive buffer, if any, should take an incoming CAN frame. Each of sixteen receive buffers holds an identifier, a frame-format flag (standard or extended) and an enable bit. An incoming identifier is compared against every buffer at once under an acceptance mask. A mask bit of 1 makes that identifier bit take part in the compare. A mask bit of 0 makes that bit a don't-care. The first fourteen buffers (0 to 13) share one global mask. Buffer 14 has its own mask, and so does buffer 15.

Identifiers are held in a 29-bit field. An extended frame uses all 29 bits. A standard 11-bit identifier sits in the upper bits [28:18], and bits [17:0] are then left out of the compare. Identifiers arrive on a valid/ready stream. The accepted identifier produces one registered result: the full match vector, a hit flag and the index of the lowest-numbered matching buffer. The delivery logic takes this result over a second valid/ready stream. Buffer entries and masks are loaded through a plain write port.

Back-pressure works as follows. The block has one result slot. A new identifier is accepted only when that slot is empty or is being drained in the same cycle. A result stays on the outputs, unchanged, until the consumer takes it.

Top module: `can_id_accept_filter`

## Requirements
- R1: After reset, res_valid is 0, id_ready is 1, every buffer is disabled and all masks are zero.
- R2: A mask bit of 1 requires the incoming identifier bit to equal the buffer's bit. A mask bit of 0 lets that bit differ without losing the match.
- R3: Buffers 0 to 13 are compared under the global mask, written at cfg_addr 16.
- R4: Buffer 14 uses only the mask at cfg_addr 17, and buffer 15 uses only the mask at cfg_addr 18. The global mask has no effect on either of them.
- R5: For a standard frame (in_ide = 0), only identifier bits [28:18] are compared. Bits [17:0] of both the incoming and the stored identifier are ignored.
- R6: A buffer matches only when its format flag equals in_ide.
- R7: A disabled buffer never shows a match bit.
- R8: When res_hit is 1, res_index is the lowest set bit of res_match. When no buffer matches, res_hit is 0 and res_index is 0.
- R9: An identifier is accepted on a cycle where id_valid and id_ready are both 1. Its result shows res_valid = 1 from the next cycle on. id_ready is 0 while res_valid is 1 and res_ready is 0.
- R10: While res_valid is 1 and res_ready is 0, the result outputs hold their values, even if the configuration is rewritten.
- R11: A write with cfg_addr below 16 loads that buffer: cfg_wdata[30] is enable, [29] is the format flag (1 = extended), and [28:0] is the identifier. A write at 16, 17 or 18 loads the addressed mask from cfg_wdata[28:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address: 0-15 buffers, 16 global mask, 17 mask for buffer 14, 18 mask for buffer 15 |
| cfg_wdata | input | 31 | Configuration write data |
| id_valid | input | 1 | Incoming identifier is valid |
| id_ready | output | 1 | Filter can accept an identifier |
| in_id | input | 29 | Incoming identifier (standard form in bits [28:18]) |
| in_ide | input | 1 | Incoming frame format, 1 = extended |
| res_valid | output | 1 | Result is valid |
| res_ready | input | 1 | Consumer takes the result |
| res_match | output | 16 | One bit per buffer that matched |
| res_hit | output | 1 | At least one buffer matched |
| res_index | output | 4 | Lowest-numbered matching buffer |

## Verification
The bench aims at the mask grouping. It gives buffers 14 and 15 masks that differ from the global mask. A design that wires them to the global mask then matches or misses in the wrong place. It sends standard frames whose low 18 bits differ from the stored identifier, and these must still match. It also sends frames whose format differs from the buffer's, and these must miss. A filter that compares all 29 bits, or skips the format check, would report the wrong vector. Several buffers are made to match at once, so that an encoder picking the highest index shows up. One result is stalled while the configuration is rewritten. A design that recomputes its output from the live configuration would show the result change, and one without back-pressure would drop or overwrite it.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int CFG_W = ID_W + 2;

  typedef logic [ID_W-1:0] ident_t;

  typedef struct packed {
    logic   en;
    logic   ext;
    ident_t id;
  } slot_cfg_t;
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ADDR_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output slot_cfg_t [NUM_BUF-1:0] slots,
  output ident_t                  mask_glb,
  output ident_t                  mask_pen,
  output ident_t                  mask_last
);
  localparam logic [ADDR_W-1:0] A_GLB  = ADDR_W'(NUM_BUF);
  localparam logic [ADDR_W-1:0] A_PEN  = ADDR_W'(NUM_BUF + 1);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NUM_BUF + 2);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots[i] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(i)) slots[i] <= slot_cfg_t'(cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_glb  <= '0;
      mask_pen  <= '0;
      mask_last <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_GLB)  mask_glb  <= cfg_wdata[ID_W-1:0];
      if (cfg_addr == A_PEN)  mask_pen  <= cfg_wdata[ID_W-1:0];
      if (cfg_addr == A_LAST) mask_last <= cfg_wdata[ID_W-1:0];
    end
  end
endmodule

// File: rtl/can_filt_compare.sv
module can_filt_compare
  import can_filt_pkg::*;
#(
  parameter int NUM_BUF = 16
) (
  input  ident_t                  in_id,
  input  logic                    in_ext,
  input  slot_cfg_t [NUM_BUF-1:0] slots,
  input  ident_t                  mask_glb,
  input  ident_t                  mask_pen,
  input  ident_t                  mask_last,
  output logic [NUM_BUF-1:0]      hit
);
  localparam int     GLB_CNT   = NUM_BUF - 2;
  localparam ident_t STD_FIELD = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  ident_t fmt_mask;
  always_comb fmt_mask = in_ext ? '1 : STD_FIELD;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_cmp
    ident_t sel_mask;
    if (i < GLB_CNT) begin : g_glb
      assign sel_mask = mask_glb;
    end else if (i == GLB_CNT) begin : g_pen
      assign sel_mask = mask_pen;
    end else begin : g_last
      assign sel_mask = mask_last;
    end
    assign hit[i] = slots[i].en && (slots[i].ext == in_ext) &&
                    (((in_id ^ slots[i].id) & sel_mask & fmt_mask) == '0);
  end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_BUF-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/can_id_accept_filter.sv
module can_id_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int IDX_W   = $clog2(NUM_BUF),
  parameter int ADDR_W  = $clog2(NUM_BUF + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               id_valid,
  output logic               id_ready,
  input  logic [ID_W-1:0]    in_id,
  input  logic               in_ide,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [NUM_BUF-1:0] res_match,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_index
);
  slot_cfg_t [NUM_BUF-1:0] slots;
  ident_t                  mask_glb, mask_pen, mask_last;
  logic [NUM_BUF-1:0]      hit_now, en_vec;
  logic                    any_now;
  logic [IDX_W-1:0]        idx_now;
  logic                    accept;

  can_filt_regs #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .slots(slots), .mask_glb(mask_glb),
    .mask_pen(mask_pen), .mask_last(mask_last)
  );

  can_filt_compare #(.NUM_BUF(NUM_BUF)) u_cmp (
    .in_id(in_id), .in_ext(in_ide), .slots(slots), .mask_glb(mask_glb),
    .mask_pen(mask_pen), .mask_last(mask_last), .hit(hit_now)
  );

  can_filt_prio #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_prio (
    .req(hit_now), .any(any_now), .idx(idx_now)
  );

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_en
    assign en_vec[i] = slots[i].en;
  end

  assign id_ready = !res_valid || res_ready;
  assign accept   = id_valid && id_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_match <= '0;
      res_hit   <= 1'b0;
      res_index <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_match <= hit_now;
      res_hit   <= any_now;
      res_index <= idx_now;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_TAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);  // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_match) && $stable(res_index) && $stable(res_hit));  // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (res_match & ~$past(en_vec)) == '0);  // R7
  AST_LOWEST_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_match[res_index] &&
      ((res_match & ~({NUM_BUF{1'b1}} << res_index)) == '0));  // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_index == '0 && res_match == '0);  // R8
endmodule

// File: tb/can_id_accept_filter_bench.sv
module can_id_accept_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [30:0] cfg_wdata = '0;
  logic        id_valid = 1'b0;
  logic        id_ready;
  logic [28:0] in_id = '0;
  logic        in_ide = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_match;
  logic        res_hit;
  logic [3:0]  res_index;

  int n_chk = 0;
  int n_bad = 0;

  logic [28:0] bid [16];
  logic        bext [16];
  logic        ben [16];
  logic [28:0] gm = '0, m14 = '0, m15 = '0;

  always #10 clk = ~clk;

  can_id_accept_filter u_can_id_accept_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .id_valid(id_valid), .id_ready(id_ready),
    .in_id(in_id), .in_ide(in_ide), .res_valid(res_valid),
    .res_ready(res_ready), .res_match(res_match), .res_hit(res_hit),
    .res_index(res_index)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [28:0] id, input logic ext);
    logic [15:0] r;
    logic [28:0] mk, fm;
    fm = ext ? '1 : {11'h7FF, 18'h0};
    for (int i = 0; i < 16; i++) begin
      mk = (i < 14) ? gm : (i == 14) ? m14 : m15;
      r[i] = ben[i] && (bext[i] == ext) && (((id ^ bid[i]) & mk & fm) == '0);
    end
    return r;
  endfunction

  function automatic logic [3:0] lowest(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [30:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 16) begin
      ben[a] = d[30]; bext[a] = d[29]; bid[a] = d[28:0];
    end else if (a == 16) gm = d[28:0];
    else if (a == 17) m14 = d[28:0];
    else if (a == 18) m15 = d[28:0];
  endtask

  task automatic buf_set(input int b, input logic en, input logic ext, input logic [28:0] id);
    wr(5'(b), {en, ext, id});
  endtask

  task automatic send(input logic [28:0] id, input logic ext, input string req);
    logic [15:0] e;
    e = model(id, ext);
    @(negedge clk);
    in_id = id; in_ide = ext; id_valid = 1'b1; res_ready = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
    chk(res_valid == 1'b1, {req, " R9 valid"}, 64'(res_valid), 64'd1);
    chk(res_match == e, {req, " match"}, 64'(res_match), 64'(e));
    chk(res_hit == (e != 0), {req, " R8 hit"}, 64'(res_hit), 64'(e != 0));
    chk(res_index == lowest(e), {req, " R8 index"}, 64'(res_index), 64'(lowest(e)));
  endtask

  localparam logic [28:0] IDA = 29'h0ABC_1234;

  initial begin
    logic [15:0] held;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 16; i++) begin bid[i] = '0; bext[i] = 1'b0; ben[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 64'd0);
    chk(id_ready == 1'b1, "R1 id_ready", 64'(id_ready), 64'd1);
    rst_n = 1'b1;
    send(IDA, 1'b1, "R1 R7 all disabled");

    // R11 R2: buffer 3 extended, full mask
    buf_set(3, 1'b1, 1'b1, IDA);
    wr(5'd16, {2'b00, 29'h1FFF_FFFF});
    send(IDA, 1'b1, "R2 R11 exact");
    send(IDA ^ 29'h1, 1'b1, "R2 bit differs");
    wr(5'd16, {2'b00, 29'h1FFF_FFFE});
    send(IDA ^ 29'h1, 1'b1, "R2 R3 dont care");

    // R4: buffer 14 and 15 own masks
    buf_set(14, 1'b1, 1'b1, IDA);
    buf_set(15, 1'b1, 1'b1, IDA);
    wr(5'd17, {2'b00, 29'h1FFF_FFFF});
    wr(5'd18, {2'b00, 29'h1FFF_FFFF});
    send(IDA ^ 29'h1, 1'b1, "R4 own mask strict");
    wr(5'd17, {2'b00, 29'h1FFF_FFFE});
    send(IDA ^ 29'h1, 1'b1, "R4 R8 buf14 relaxed");
    wr(5'd16, {2'b00, 29'h1FFF_FFFF});
    send(IDA ^ 29'h1, 1'b1, "R4 R3 global strict only buf14");
    chk(res_match == 16'h4000, "R4 explicit vector", 64'(res_match), 64'h4000);

    // R5 R6: standard frames
    buf_set(5, 1'b1, 1'b0, {11'h5A3, 18'h2AAAA});
    send({11'h5A3, 18'h15555}, 1'b0, "R5 low bits ignored");
    chk(res_match == 16'h0020, "R5 explicit vector", 64'(res_match), 64'h0020);
    send({11'h5A3, 18'h2AAAA}, 1'b1, "R6 format differs");
    chk(res_hit == 1'b0, "R6 explicit miss", 64'(res_hit), 64'd0);
    send({11'h5A2, 18'h2AAAA}, 1'b0, "R5 upper bit differs");

    // R8: several matches, lowest wins
    buf_set(9, 1'b1, 1'b1, IDA);
    buf_set(2, 1'b1, 1'b1, IDA);
    send(IDA, 1'b1, "R8 multi");
    chk(res_index == 4'd2, "R8 lowest explicit", 64'(res_index), 64'd2);
    buf_set(2, 1'b0, 1'b1, IDA);
    send(IDA, 1'b1, "R7 disabled skipped");
    chk(res_index == 4'd3, "R7 next lowest", 64'(res_index), 64'd3);

    // R9 R10: stall with config rewrite
    @(negedge clk);
    in_id = IDA; in_ide = 1'b1; id_valid = 1'b1; res_ready = 1'b0;
    @(negedge clk);
    id_valid = 1'b0;
    held = res_match;
    chk(res_valid == 1'b1, "R9 stall valid", 64'(res_valid), 64'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(id_ready == 1'b0, "R9 backpressure", 64'(id_ready), 64'd0);
      chk(res_valid == 1'b1, "R9 held valid", 64'(res_valid), 64'd1);
    end
    buf_set(3, 1'b0, 1'b1, IDA);
    buf_set(9, 1'b0, 1'b1, IDA);
    chk(res_match == held, "R10 stable under cfg write", 64'(res_match), 64'(held));
    chk(res_index == 4'd3, "R10 index held", 64'(res_index), 64'd3);
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R9 drained", 64'(res_valid), 64'd0);

    // Random phase R2-R8
    for (int it = 0; it < 400; it++) begin
      if (it % 25 == 0) begin
        for (int b = 0; b < 16; b++)
          buf_set(b, ($urandom % 4) != 0, $urandom % 2, 29'($urandom));
        wr(5'd16, {2'b00, ~29'($urandom & $urandom & $urandom)});
        wr(5'd17, {2'b00, ~29'($urandom & $urandom)});
        wr(5'd18, {2'b00, ~29'($urandom & $urandom & $urandom)});
      end
      begin
        int k;
        logic [28:0] id;
        logic ext;
        k = $urandom % 16;
        id = bid[k];
        if ($urandom % 2) id = id ^ (29'd1 << ($urandom % 29));
        if ($urandom % 4 == 0) id = id ^ 29'($urandom);
        ext = ($urandom % 8 == 0) ? ~bext[k] : bext[k];
        send(id, ext, "R2 R3 R4 R5 R6 R8 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule